// File: doc/BRIEF.md
# Ternary/Binary Line Symbol Codec

This block carries 3-bit data groups over one data pin as a stream of three-level line symbols, and recovers them on the far side. The encoder accepts a group through a valid/ready handshake and emits it either as two ternary symbols (PAM3 mode, 1.5 bits per symbol cycle) or as three binary symbols (NRZ mode, one bit per cycle). A mode input picks the scheme per group, so the link can run the denser scheme when bandwidth is needed and the two-level scheme when it is not.

The encoder marks the first symbol of each group with a frame strobe. The decoder takes a symbol stream plus a frame strobe and its own mode input. It rebuilds the group, presents it with a one-cycle valid strobe, and raises an error strobe instead when the symbols cannot be a legal group. Encoder and decoder sides have separate ports so they can be looped back or driven apart. Line levels are digital codes only.

Top module: `tl_codec`

## Requirements
- R1: Symbol codes are 2'b11 for -1, 2'b00 for 0 and 2'b01 for +1; the encoder never emits 2'b10.
- R2: In PAM3 mode a group v is sent as (first, second) with 000=(-1,-1), 001=(-1,0), 010=(-1,+1), 011=(0,-1), 100=(0,+1), 101=(+1,-1), 110=(+1,0), 111=(+1,+1); the first symbol appears in the cycle after the handshake, with enc_frame_o high on it only.
- R3: In PAM3 mode the encoder never emits the pair (0,0) for a group.
- R4: The mode of a group is taken from enc_pam3_i (1 = PAM3, 0 = NRZ) at its handshake; changing the mode input while a group is on the line has no effect on that group.
- R5: In NRZ mode a group is sent as three symbols, most significant bit first, -1 for a 0 bit and +1 for a 1 bit.
- R6: in_ready_o is high while idle and during the last symbol of a group, so groups follow back to back: one group per 2 cycles in PAM3, per 3 cycles in NRZ.
- R7: With no group on the line the encoder outputs symbol 0 with enc_frame_o low.
- R8: The decoder, given a framed group whose mode matches dec_pam3_i at the frame symbol, raises out_valid_o for one cycle with the group on out_data_o in the cycle after it captures the last symbol.
- R9: For a framed group holding a 2'b10 code, a PAM3 pair (0,0), or a 0 symbol in NRZ mode, the decoder raises out_err_o for one cycle in place of out_valid_o.
- R10: Symbols received while no group is being collected and without the frame strobe (idle zeros included) produce neither valid nor error.
- R11: After reset in_ready_o is high, enc_sym_o is 0, enc_frame_o, out_valid_o and out_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_pam3_i | input | 1 | Encoder mode for the next group: 1 PAM3, 0 NRZ |
| in_valid_i | input | 1 | Input group valid |
| in_ready_o | output | 1 | Encoder can take a group this cycle |
| in_data_i | input | 3 | Input data group |
| enc_sym_o | output | 2 | Line symbol code |
| enc_frame_o | output | 1 | High on the first symbol of a group |
| dec_pam3_i | input | 1 | Decoder mode, sampled with the frame symbol |
| dec_frame_i | input | 1 | Frame strobe from the line |
| dec_sym_i | input | 2 | Line symbol code into the decoder |
| out_valid_o | output | 1 | Recovered group valid, one cycle |
| out_data_o | output | 3 | Recovered group |
| out_err_o | output | 1 | Illegal group received, one cycle |

## Verification
The assertions watch every cycle for the encoder never driving the illegal code, never forming the reserved pair in PAM3, keeping NRZ symbols binary, idling at zero, holding its group mode until the next frame, and the decoder never flagging valid and error together. The exact bit-to-symbol mapping, bit order, back-to-back throughput, the decoder's latency and its reaction to injected bad or unframed symbols are only shown by the bench's directed scenarios, which compare against tables written from the requirements.

// File: rtl/tl_codec_pkg.sv
package tl_codec_pkg;
  localparam int GRP_W = 3;
  localparam int SYM_W = 2;
  localparam int PH_W  = 2;

  localparam logic [SYM_W-1:0] SYM_NEG  = 2'b11;
  localparam logic [SYM_W-1:0] SYM_ZERO = 2'b00;
  localparam logic [SYM_W-1:0] SYM_POS  = 2'b01;
  localparam logic [SYM_W-1:0] SYM_BAD  = 2'b10;

  // ternary digit 0..2 -> symbol code (-1,0,+1)
  function automatic logic [SYM_W-1:0] digit_to_sym(input logic [1:0] d);
    case (d)
      2'd0:    return SYM_NEG;
      2'd1:    return SYM_ZERO;
      default: return SYM_POS;
    endcase
  endfunction

  function automatic logic [1:0] sym_to_digit(input logic [SYM_W-1:0] s);
    case (s)
      SYM_NEG:  return 2'd0;
      SYM_ZERO: return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction

  // group -> base-3 index 0..8, skipping the reserved middle index 4
  function automatic logic [3:0] grp_to_idx(input logic [GRP_W-1:0] v);
    return (v < 3'd4) ? {1'b0, v} : {1'b0, v} + 4'd1;
  endfunction

  function automatic logic [GRP_W-1:0] idx_to_grp(input logic [3:0] idx);
    logic [3:0] t;
    t = (idx < 4'd4) ? idx : idx - 4'd1;
    return t[GRP_W-1:0];
  endfunction
endpackage

// File: rtl/tl_encoder.sv
module tl_encoder
  import tl_codec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pam3_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [GRP_W-1:0] data_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             frame_o
);
  localparam logic [PH_W-1:0] LAST_PAM3 = PH_W'(1);
  localparam logic [PH_W-1:0] LAST_NRZ  = PH_W'(GRP_W - 1);

  logic             busy_q, pam3_q;
  logic [GRP_W-1:0] grp_q;
  logic [PH_W-1:0]  ph_q;
  logic             last;
  logic [3:0]       idx;
  logic [1:0]       hi_d, lo_d;
  logic             nrz_bit;

  assign last    = busy_q && (ph_q == (pam3_q ? LAST_PAM3 : LAST_NRZ));
  assign ready_o = !busy_q || last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pam3_q <= 1'b0;
      grp_q  <= '0;
      ph_q   <= '0;
    end else if (valid_i && ready_o) begin
      busy_q <= 1'b1;
      pam3_q <= pam3_i;   // mode fixed per group
      grp_q  <= data_i;
      ph_q   <= '0;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      ph_q   <= ph_q + 1'b1;
    end
  end

  always_comb begin
    idx     = grp_to_idx(grp_q);
    hi_d    = 2'(idx / 4'd3);
    lo_d    = 2'(idx % 4'd3);
    nrz_bit = grp_q[GRP_W - 1 - int'(ph_q)];
    if (!busy_q)     sym_o = SYM_ZERO;
    else if (pam3_q) sym_o = digit_to_sym(ph_q == '0 ? hi_d : lo_d);
    else             sym_o = nrz_bit ? SYM_POS : SYM_NEG;
  end

  assign frame_o = busy_q && (ph_q == '0);
endmodule

// File: rtl/tl_decoder.sv
module tl_decoder
  import tl_codec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pam3_i,
  input  logic             frame_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             valid_o,
  output logic [GRP_W-1:0] data_o,
  output logic             err_o
);
  localparam logic [PH_W-1:0] LAST_PAM3 = PH_W'(1);
  localparam logic [PH_W-1:0] LAST_NRZ  = PH_W'(GRP_W - 1);

  logic             col_q, pam3_q, bad_q;
  logic [PH_W-1:0]  ph_q;
  logic [SYM_W-1:0] s0_q;
  logic [GRP_W-1:0] acc_q;
  logic             bad_first, bad_next, last;
  logic [3:0]       idx;

  assign bad_first = (sym_i == SYM_BAD) || (!pam3_i && sym_i == SYM_ZERO);
  assign bad_next  = bad_q || (sym_i == SYM_BAD)
                   || (!pam3_q && sym_i == SYM_ZERO)
                   || (pam3_q && s0_q == SYM_ZERO && sym_i == SYM_ZERO);
  assign last      = ph_q == (pam3_q ? LAST_PAM3 : LAST_NRZ);
  assign idx       = 4'(sym_to_digit(s0_q)) * 4'd3 + 4'(sym_to_digit(sym_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= 1'b0;
      pam3_q  <= 1'b0;
      bad_q   <= 1'b0;
      ph_q    <= '0;
      s0_q    <= SYM_ZERO;
      acc_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (frame_i) begin
        col_q  <= 1'b1;
        pam3_q <= pam3_i;
        ph_q   <= PH_W'(1);
        s0_q   <= sym_i;
        bad_q  <= bad_first;
        acc_q  <= {{(GRP_W-1){1'b0}}, sym_i == SYM_POS};
      end else if (col_q) begin
        if (last) begin
          col_q   <= 1'b0;
          valid_o <= !bad_next;
          err_o   <= bad_next;
          data_o  <= pam3_q ? idx_to_grp(idx)
                            : {acc_q[GRP_W-2:0], sym_i == SYM_POS};
        end else begin
          ph_q  <= ph_q + 1'b1;
          bad_q <= bad_next;
          acc_q <= {acc_q[GRP_W-2:0], sym_i == SYM_POS};
        end
      end
    end
  end
endmodule

// File: rtl/tl_codec.sv
module tl_codec
  import tl_codec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enc_pam3_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [GRP_W-1:0] in_data_i,
  output logic [SYM_W-1:0] enc_sym_o,
  output logic             enc_frame_o,
  input  logic             dec_pam3_i,
  input  logic             dec_frame_i,
  input  logic [SYM_W-1:0] dec_sym_i,
  output logic             out_valid_o,
  output logic [GRP_W-1:0] out_data_o,
  output logic             out_err_o
);
  tl_encoder u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pam3_i  (enc_pam3_i),
    .valid_i (in_valid_i),
    .ready_o (in_ready_o),
    .data_i  (in_data_i),
    .sym_o   (enc_sym_o),
    .frame_o (enc_frame_o)
  );

  tl_decoder u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pam3_i  (dec_pam3_i),
    .frame_i (dec_frame_i),
    .sym_i   (dec_sym_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .err_o   (out_err_o)
  );
endmodule

// File: rtl/tl_codec_chk.sv
module tl_codec_chk
  import tl_codec_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SYM_W-1:0] enc_sym_o,
  input logic             enc_frame_o,
  input logic             enc_busy,
  input logic             enc_pam3,
  input logic             out_valid_o,
  input logic             out_err_o
);
  a_r1_no_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_sym_o != SYM_BAD);

  a_r3_no_reserved_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_frame_o && enc_pam3 && enc_sym_o == SYM_ZERO) |=> enc_sym_o != SYM_ZERO);

  a_r4_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_busy && !enc_frame_o) |-> $stable(enc_pam3));

  a_r5_nrz_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_busy && !enc_pam3) |-> (enc_sym_o == SYM_NEG || enc_sym_o == SYM_POS));

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_busy |-> (enc_sym_o == SYM_ZERO && !enc_frame_o));

  a_r9_valid_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_valid_o, out_err_o}));
endmodule

bind tl_codec tl_codec_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enc_sym_o   (enc_sym_o),
  .enc_frame_o (enc_frame_o),
  .enc_busy    (u_enc.busy_q),
  .enc_pam3    (u_enc.pam3_q),
  .out_valid_o (out_valid_o),
  .out_err_o   (out_err_o)
);

// File: tb/test_tl_codec.sv
module test_tl_codec;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] NEG = 2'b11, ZER = 2'b00, POS = 2'b01, BAD = 2'b10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enc_pam3_i = 1'b0, in_valid_i = 1'b0, dec_pam3_i = 1'b0;
  logic [2:0] in_data_i = '0;
  logic in_ready_o, enc_frame_o, out_valid_o, out_err_o;
  logic [1:0] enc_sym_o;
  logic [2:0] out_data_o;
  logic inj = 1'b0, inj_frame = 1'b0;
  logic [1:0] inj_sym = 2'b00;
  logic dec_frame_i;
  logic [1:0] dec_sym_i;

  int n_chk = 0, n_bad = 0;

  assign dec_frame_i = inj ? inj_frame : enc_frame_o;
  assign dec_sym_i   = inj ? inj_sym   : enc_sym_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tl_codec i_tl_codec (
    .clk_i(clk_i), .rst_ni(rst_ni), .enc_pam3_i(enc_pam3_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .enc_sym_o(enc_sym_o), .enc_frame_o(enc_frame_o), .dec_pam3_i(dec_pam3_i),
    .dec_frame_i(dec_frame_i), .dec_sym_i(dec_sym_i), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_err_o(out_err_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] pam3_first(input logic [2:0] v);
    case (v)
      3'd0, 3'd1, 3'd2: return NEG;
      3'd3, 3'd4:       return ZER;
      default:          return POS;
    endcase
  endfunction

  function automatic logic [1:0] pam3_second(input logic [2:0] v);
    case (v)
      3'd0, 3'd3, 3'd5: return NEG;
      3'd1, 3'd6:       return ZER;
      default:          return POS;
    endcase
  endfunction

  function automatic logic [1:0] exp_sym(input bit pam3, input logic [2:0] v, input int k);
    if (pam3) return (k == 0) ? pam3_first(v) : pam3_second(v);
    return v[2-k] ? POS : NEG;
  endfunction

  task automatic t_reset();
    chk(in_ready_o == 1'b1, "R11 ready", int'(in_ready_o), 1);
    chk(enc_sym_o == ZER && !enc_frame_o, "R11 line idle", int'(enc_sym_o), 0);
    chk(!out_valid_o && !out_err_o, "R11 dec quiet", int'({out_valid_o, out_err_o}), 0);
  endtask

  // one group, mode input flipped right after handshake (R4)
  task automatic t_group(input bit pam3, input logic [2:0] v);
    int n;
    n = pam3 ? 2 : 3;
    @(negedge clk_i);
    enc_pam3_i = pam3; dec_pam3_i = pam3; in_valid_i = 1'b1; in_data_i = v;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0; enc_pam3_i = ~pam3;
    for (int k = 0; k < n; k++) begin
      chk(enc_sym_o == exp_sym(pam3, v, k), pam3 ? "R2 R4 pam3 symbol" : "R5 R4 nrz symbol",
          int'(enc_sym_o), int'(exp_sym(pam3, v, k)));
      chk(enc_frame_o == (k == 0), "R2 frame", int'(enc_frame_o), int'(k == 0));
      chk(enc_sym_o != BAD, "R1 code", int'(enc_sym_o), 0);
      if (pam3 && k == 1)
        chk(!(enc_sym_o == ZER && pam3_first(v) == ZER), "R3 pair", int'(enc_sym_o), 1);
      chk(!out_valid_o, "R8 early", int'(out_valid_o), 0);
      @(negedge clk_i);
    end
    chk(out_valid_o && !out_err_o, "R8 valid", int'({out_valid_o, out_err_o}), 2);
    chk(out_data_o == v, "R8 data", int'(out_data_o), int'(v));
    @(negedge clk_i);
    chk(!out_valid_o, "R8 one cycle", int'(out_valid_o), 0);
  endtask

  // four groups back to back
  task automatic t_stream(input bit pam3, input logic [2:0] v0, input logic [2:0] v1,
                          input logic [2:0] v2, input logic [2:0] v3);
    logic [2:0] vs [4];
    int n;
    vs[0] = v0; vs[1] = v1; vs[2] = v2; vs[3] = v3;
    n = pam3 ? 2 : 3;
    @(negedge clk_i);
    enc_pam3_i = pam3; dec_pam3_i = pam3; in_valid_i = 1'b1; in_data_i = vs[0];
    chk(in_ready_o, "R6 idle ready", int'(in_ready_o), 1);
    @(negedge clk_i);
    for (int k = 0; k < 4*n; k++) begin
      int g;
      g = k / n;
      if (k % n == 0) begin
        if (g < 3) in_data_i = vs[g+1];
        else in_valid_i = 1'b0;
        if (g > 0) chk(out_valid_o && out_data_o == vs[g-1], "R6 R8 stream out",
                       int'(out_data_o), int'(vs[g-1]));
      end
      chk(enc_sym_o == exp_sym(pam3, vs[g], k % n), "R6 stream symbol",
          int'(enc_sym_o), int'(exp_sym(pam3, vs[g], k % n)));
      chk(in_ready_o == (k % n == n - 1), "R6 ready timing", int'(in_ready_o),
          int'(k % n == n - 1));
      @(negedge clk_i);
    end
    chk(out_valid_o && out_data_o == vs[3], "R6 R8 last out", int'(out_data_o), int'(vs[3]));
    chk(enc_sym_o == ZER && !enc_frame_o, "R7 after stream", int'(enc_sym_o), 0);
  endtask

  task automatic t_idle(input int cycles);
    inj = 1'b0; in_valid_i = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      chk(enc_sym_o == ZER && !enc_frame_o, "R7 idle line", int'(enc_sym_o), 0);
      chk(!out_valid_o && !out_err_o, "R10 idle zeros", int'({out_valid_o, out_err_o}), 0);
    end
  endtask

  // unframed junk including the illegal code
  task automatic t_unframed();
    @(negedge clk_i);
    inj = 1'b1; inj_frame = 1'b0;
    for (int c = 0; c < 6; c++) begin
      inj_sym = (c % 2 == 0) ? BAD : ZER;
      @(negedge clk_i);
      chk(!out_valid_o && !out_err_o, "R10 unframed", int'({out_valid_o, out_err_o}), 0);
    end
    inj = 1'b0; inj_sym = ZER;
  endtask

  task automatic t_inject(input bit pam3, input logic [1:0] s0, input logic [1:0] s1,
                          input logic [1:0] s2, input bit exp_err, input logic [2:0] exp_v,
                          input string req);
    @(negedge clk_i);
    inj = 1'b1; dec_pam3_i = pam3; inj_frame = 1'b1; inj_sym = s0;
    @(negedge clk_i);
    inj_frame = 1'b0; inj_sym = s1;
    if (!pam3) begin
      @(negedge clk_i);
      inj_sym = s2;
    end
    @(negedge clk_i);
    inj_sym = ZER;
    chk(out_err_o == exp_err, req, int'(out_err_o), int'(exp_err));
    chk(out_valid_o == !exp_err, req, int'(out_valid_o), int'(!exp_err));
    if (!exp_err) chk(out_data_o == exp_v, req, int'(out_data_o), int'(exp_v));
    @(negedge clk_i);
    chk(!out_err_o && !out_valid_o, "R9 strobe one cycle", int'({out_valid_o, out_err_o}), 0);
    inj = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    for (int v = 0; v < 8; v++) t_group(1'b1, 3'(v));
    for (int v = 0; v < 8; v++) t_group(1'b0, 3'(v));
    t_stream(1'b1, 3'd3, 3'd4, 3'd7, 3'd0);
    t_stream(1'b0, 3'd5, 3'd2, 3'd6, 3'd1);
    t_idle(8);
    t_unframed();
    t_inject(1'b1, POS, NEG, ZER, 1'b0, 3'd5, "R8 injected pam3 101");
    t_inject(1'b1, ZER, ZER, ZER, 1'b1, 3'd0, "R9 reserved pair");
    t_inject(1'b1, NEG, BAD, ZER, 1'b1, 3'd0, "R9 bad code");
    t_inject(1'b0, POS, ZER, POS, 1'b1, 3'd0, "R9 nrz zero");
    t_inject(1'b0, POS, NEG, POS, 1'b0, 3'd5, "R8 injected nrz 101");
    t_idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule